// File: doc/BRIEF.md
# Operating Point Table Search

This block holds a small table of operating points for one processor cluster and searches it one entry per clock cycle. Each entry is a 32-bit word that pairs a supply level in millivolts with a frequency code. The frequency in kHz is the code times a fixed multiplier. Software or a neighbouring controller fills the table through a plain write port. It then starts a search with a one-cycle start pulse, a mode bit, a requested frequency in kHz and the number of valid entries.

In rounding mode the block answers with the lowest supported frequency that meets or exceeds the request. When every entry lies below the request, it answers with the highest entry instead. In exact mode it answers with the first table index whose frequency equals the request, or it flags the result invalid. A one-cycle done pulse carries the result: a valid flag, the entry index, its frequency in kHz and its millivolt field. The result outputs keep their values until the next done pulse.

Top module: `opp_search_top`

## Requirements
- R1: A table word carries the millivolt field in bits [31:20] and the frequency code in bits [19:0]. A reported frequency is code × 20 in kHz. The reported millivolt value is bits [31:20] of the selected entry.
- R2: A start pulse is accepted only while `busy_o` is low. A start pulse that arrives while a search is running has no effect on that search or its result.
- R3: `count_i` is sampled when the start is accepted. Values above 8 are treated as 8. Only entries 0 to count−1 take part in the search, and a valid result index is always below the count.
- R4: `busy_o` is high from the cycle after an accepted start until `done_o`. `done_o` is a one-cycle pulse that rises max(count,1) clock edges after the accepting edge.
- R5: Rounding mode (`mode_i` = 0) reports the smallest table frequency that is greater than or equal to the request, with valid set.
- R6: In rounding mode, when no entry reaches the request, the block reports the largest table frequency below it, with valid set.
- R7: Exact mode (`mode_i` = 1) reports the lowest index whose frequency equals the request, with valid set.
- R8: When exact mode finds no match, valid is low and the index, frequency and millivolt outputs are zero.
- R9: With a count of zero, both modes report invalid.
- R10: The result outputs (valid, index, frequency, millivolts) hold their values between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Table write strobe |
| wr_idx_i | input | 3 | Table entry to write |
| wr_data_i | input | 32 | Entry word: millivolts [31:20], frequency code [19:0] |
| start_i | input | 1 | Search start pulse |
| mode_i | input | 1 | 0 = rounding, 1 = exact |
| count_i | input | 4 | Number of valid entries (values above 8 are clamped to 8) |
| req_khz_i | input | 25 | Requested frequency in kHz |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle result pulse |
| valid_o | output | 1 | Result is meaningful |
| idx_o | output | 3 | Selected entry index |
| freq_khz_o | output | 25 | Selected frequency in kHz |
| mv_o | output | 12 | Selected millivolt field |

## Verification
Two things can fall in the same cycle. First, a new start pulse can arrive while the scan is still running. Second, the scan can reach its final entry on the same edge where the done pulse and the result are produced. The bench provokes both by holding start high, with a different mode and request, for the whole of some searches, including the edge on which done is registered. It then judges the result against the original request and checks that the measured latency is still max(count,1). Sweeps over table shapes with duplicate frequencies, over counts from 0 to 9, and over requests just below, at and just above every entry cover the tie, fallback and clamping corners.

// File: rtl/opp_search_pkg.sv
package opp_search_pkg;
  typedef enum logic {
    MODE_ROUND = 1'b0,
    MODE_EXACT = 1'b1
  } search_mode_e;
endpackage

// File: rtl/opp_table.sv
module opp_table #(
  parameter int ENTRIES = 8,
  parameter int WORD_W  = 32,
  parameter int IDX_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0] rd_word_o
);
  logic [WORD_W-1:0] word_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic wr_hit;
    assign wr_hit = wr_en_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      word_q[g] <= '0;
      else if (wr_hit) word_q[g] <= wr_data_i;
    end
  end

  assign rd_word_o = word_q[rd_idx_i];
endmodule

// File: rtl/opp_decode.sv
module opp_decode #(
  parameter int WORD_W = 32,
  parameter int CODE_W = 20,
  parameter int MV_W   = 12,
  parameter int MULT   = 20,
  parameter int KHZ_W  = 25
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [KHZ_W-1:0]  khz_o,
  output logic [MV_W-1:0]   mv_o
);
  logic [CODE_W-1:0] code;
  assign code  = word_i[CODE_W-1:0];
  assign mv_o  = word_i[CODE_W +: MV_W];
  assign khz_o = KHZ_W'(code) * KHZ_W'(MULT);
endmodule

// File: rtl/opp_scan.sv
module opp_scan
  import opp_search_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3,
  parameter int CNT_W   = 4,
  parameter int KHZ_W   = 25,
  parameter int MV_W    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [KHZ_W-1:0] req_i,
  input  logic [KHZ_W-1:0] ent_khz_i,
  input  logic [MV_W-1:0]  ent_mv_i,
  output logic [IDX_W-1:0] cur_idx_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [KHZ_W-1:0] freq_o,
  output logic [MV_W-1:0]  mv_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ENTRIES);

  // control state
  logic busy_q, busy_d, empty_q, empty_d, done_q, done_d;
  search_mode_e mode_q, mode_d;
  logic [KHZ_W-1:0] req_q, req_d;
  logic [IDX_W-1:0] cur_q, cur_d, last_q, last_d;
  // trackers: smallest at/above, largest below, first equal
  logic             ge_v_q, ge_v_d, lt_v_q, lt_v_d, eq_v_q, eq_v_d;
  logic [IDX_W-1:0] ge_i_q, ge_i_d, lt_i_q, lt_i_d, eq_i_q, eq_i_d;
  logic [KHZ_W-1:0] ge_f_q, ge_f_d, lt_f_q, lt_f_d;
  logic [MV_W-1:0]  ge_m_q, ge_m_d, lt_m_q, lt_m_d, eq_m_q, eq_m_d;
  // result
  logic             res_v_q, res_v_d;
  logic [IDX_W-1:0] res_i_q, res_i_d;
  logic [KHZ_W-1:0] res_f_q, res_f_d;
  logic [MV_W-1:0]  res_m_q, res_m_d;

  logic [CNT_W-1:0] cnt_clamp;
  logic ge_take, lt_take, eq_take;

  assign cnt_clamp = (count_i > CNT_MAX) ? CNT_MAX : count_i;
  assign ge_take = (ent_khz_i >= req_q) && (!ge_v_q || ent_khz_i < ge_f_q);
  assign lt_take = (ent_khz_i <  req_q) && (!lt_v_q || ent_khz_i > lt_f_q);
  assign eq_take = (ent_khz_i == req_q) && !eq_v_q;

  always_comb begin
    busy_d = busy_q;  empty_d = empty_q;  done_d = 1'b0;
    mode_d = mode_q;  req_d = req_q;  cur_d = cur_q;  last_d = last_q;
    ge_v_d = ge_v_q;  ge_i_d = ge_i_q;  ge_f_d = ge_f_q;  ge_m_d = ge_m_q;
    lt_v_d = lt_v_q;  lt_i_d = lt_i_q;  lt_f_d = lt_f_q;  lt_m_d = lt_m_q;
    eq_v_d = eq_v_q;  eq_i_d = eq_i_q;  eq_m_d = eq_m_q;
    res_v_d = res_v_q; res_i_d = res_i_q; res_f_d = res_f_q; res_m_d = res_m_q;

    if (!busy_q) begin
      if (start_i) begin
        busy_d  = 1'b1;
        empty_d = (cnt_clamp == '0);
        mode_d  = search_mode_e'(mode_i);
        req_d   = req_i;
        cur_d   = '0;
        last_d  = IDX_W'(cnt_clamp - CNT_W'(1));
        ge_v_d  = 1'b0;
        lt_v_d  = 1'b0;
        eq_v_d  = 1'b0;
      end
    end else if (empty_q) begin
      busy_d = 1'b0;  done_d = 1'b0 | 1'b1;
      res_v_d = 1'b0; res_i_d = '0; res_f_d = '0; res_m_d = '0;
    end else begin
      if (ge_take) begin ge_v_d = 1'b1; ge_i_d = cur_q; ge_f_d = ent_khz_i; ge_m_d = ent_mv_i; end
      if (lt_take) begin lt_v_d = 1'b1; lt_i_d = cur_q; lt_f_d = ent_khz_i; lt_m_d = ent_mv_i; end
      if (eq_take) begin eq_v_d = 1'b1; eq_i_d = cur_q; eq_m_d = ent_mv_i; end
      if (cur_q == last_q) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        res_v_d = 1'b0; res_i_d = '0; res_f_d = '0; res_m_d = '0;
        if (mode_q == MODE_EXACT) begin
          if (eq_v_d) begin
            res_v_d = 1'b1; res_i_d = eq_i_d; res_f_d = req_q; res_m_d = eq_m_d;
          end
        end else if (ge_v_d) begin
          res_v_d = 1'b1; res_i_d = ge_i_d; res_f_d = ge_f_d; res_m_d = ge_m_d;
        end else if (lt_v_d) begin
          res_v_d = 1'b1; res_i_d = lt_i_d; res_f_d = lt_f_d; res_m_d = lt_m_d;
        end
      end else begin
        cur_d = cur_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; empty_q <= 1'b0; done_q <= 1'b0;
      mode_q <= MODE_ROUND; req_q <= '0; cur_q <= '0; last_q <= '0;
      ge_v_q <= 1'b0; ge_i_q <= '0; ge_f_q <= '0; ge_m_q <= '0;
      lt_v_q <= 1'b0; lt_i_q <= '0; lt_f_q <= '0; lt_m_q <= '0;
      eq_v_q <= 1'b0; eq_i_q <= '0; eq_m_q <= '0;
      res_v_q <= 1'b0; res_i_q <= '0; res_f_q <= '0; res_m_q <= '0;
    end else begin
      busy_q <= busy_d; empty_q <= empty_d; done_q <= done_d;
      mode_q <= mode_d; req_q <= req_d; cur_q <= cur_d; last_q <= last_d;
      ge_v_q <= ge_v_d; ge_i_q <= ge_i_d; ge_f_q <= ge_f_d; ge_m_q <= ge_m_d;
      lt_v_q <= lt_v_d; lt_i_q <= lt_i_d; lt_f_q <= lt_f_d; lt_m_q <= lt_m_d;
      eq_v_q <= eq_v_d; eq_i_q <= eq_i_d; eq_m_q <= eq_m_d;
      res_v_q <= res_v_d; res_i_q <= res_i_d; res_f_q <= res_f_d; res_m_q <= res_m_d;
    end
  end

  assign cur_idx_o = cur_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign valid_o   = res_v_q;
  assign idx_o     = res_i_q;
  assign freq_o    = res_f_q;
  assign mv_o      = res_m_q;
endmodule

// File: rtl/opp_search_top.sv
module opp_search_top #(
  parameter int ENTRIES = 8,
  parameter int CODE_W  = 20,
  parameter int MV_W    = 12,
  parameter int MULT    = 20,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int CNT_W   = $clog2(ENTRIES + 1),
  parameter int WORD_W  = CODE_W + MV_W,
  parameter int KHZ_W   = CODE_W + $clog2(MULT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [KHZ_W-1:0]  req_khz_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              valid_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [KHZ_W-1:0]  freq_khz_o,
  output logic [MV_W-1:0]   mv_o
);
  logic [IDX_W-1:0]  cur_idx;
  logic [WORD_W-1:0] cur_word;
  logic [KHZ_W-1:0]  cur_khz;
  logic [MV_W-1:0]   cur_mv;

  opp_table #(.ENTRIES(ENTRIES), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
    .rd_idx_i(cur_idx), .rd_word_o(cur_word)
  );

  opp_decode #(.WORD_W(WORD_W), .CODE_W(CODE_W), .MV_W(MV_W),
               .MULT(MULT), .KHZ_W(KHZ_W)) u_decode (
    .word_i(cur_word), .khz_o(cur_khz), .mv_o(cur_mv)
  );

  opp_scan #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W),
             .KHZ_W(KHZ_W), .MV_W(MV_W)) u_scan (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_i), .mode_i(mode_i), .count_i(count_i), .req_i(req_khz_i),
    .ent_khz_i(cur_khz), .ent_mv_i(cur_mv), .cur_idx_o(cur_idx),
    .busy_o(busy_o), .done_o(done_o), .valid_o(valid_o),
    .idx_o(idx_o), .freq_o(freq_khz_o), .mv_o(mv_o)
  );
endmodule

// File: rtl/opp_search_chk.sv
module opp_search_chk #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3,
  parameter int CNT_W   = 4,
  parameter int KHZ_W   = 25,
  parameter int MV_W    = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             mode_i,
  input logic [CNT_W-1:0] count_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             valid_o,
  input logic [IDX_W-1:0] idx_o,
  input logic [KHZ_W-1:0] freq_khz_o,
  input logic [MV_W-1:0]  mv_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ENTRIES);

  logic             mode_c;
  logic [CNT_W-1:0] cnt_c;
  logic [CNT_W:0]   lat_c;
  logic [CNT_W:0]   lat_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_c <= 1'b0; cnt_c <= '0; lat_c <= '0;
    end else if (start_i && !busy_o) begin
      mode_c <= mode_i;
      cnt_c  <= (count_i > CNT_MAX) ? CNT_MAX : count_i;
      lat_c  <= '0;
    end else if (busy_o) begin
      lat_c  <= lat_c + 1'b1;
    end
  end

  assign lat_exp = (cnt_c == '0) ? (CNT_W+1)'(1) : {1'b0, cnt_c};

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R4
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> lat_c == lat_exp); // R4
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R4
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i)); // R2
  AST_EMPTY_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cnt_c == '0) |-> !valid_o); // R9
  AST_ROUND_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !mode_c && cnt_c != '0) |-> valid_o); // R5
  AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !valid_o) |-> (idx_o == '0 && freq_khz_o == '0 && mv_o == '0)); // R8
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && valid_o) |-> {1'b0, idx_o} < (IDX_W+1)'(cnt_c)); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> (!done_o |-> ($stable(valid_o) && $stable(idx_o) && $stable(freq_khz_o)))); // R10
endmodule

bind opp_search_top opp_search_chk #(
  .ENTRIES(ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W), .KHZ_W(KHZ_W), .MV_W(MV_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .count_i(count_i),
  .busy_o(busy_o), .done_o(done_o), .valid_o(valid_o), .idx_o(idx_o),
  .freq_khz_o(freq_khz_o), .mv_o(mv_o)
);

// File: tb/sim_opp_search_top.sv
module sim_opp_search_top;
  logic        clk, rst_n;
  logic        wr_en_i;
  logic [2:0]  wr_idx_i;
  logic [31:0] wr_data_i;
  logic        start_i, mode_i;
  logic [3:0]  count_i;
  logic [24:0] req_khz_i;
  logic        busy_o, done_o, valid_o;
  logic [2:0]  idx_o;
  logic [24:0] freq_khz_o;
  logic [11:0] mv_o;

  int checks = 0, errors = 0;
  int tbl_khz [8];
  int tbl_mv  [8];

  opp_search_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
    .wr_data_i(wr_data_i), .start_i(start_i), .mode_i(mode_i), .count_i(count_i),
    .req_khz_i(req_khz_i), .busy_o(busy_o), .done_o(done_o), .valid_o(valid_o),
    .idx_o(idx_o), .freq_khz_o(freq_khz_o), .mv_o(mv_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input int pat);
    for (int i = 0; i < 8; i++) begin
      int code;
      code = ((i * pat + 3) % 9) * 5 + 1;
      tbl_khz[i] = code * 20;
      tbl_mv[i]  = 100 + 37 * i;
      @(negedge clk);
      wr_en_i = 1'b1; wr_idx_i = 3'(i);
      wr_data_i = {12'(tbl_mv[i]), 20'(code)};
    end
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic model(input bit md, input int req, input int cnt,
                       output bit v, output int f, output int ix);
    int n, gef, ltf, gei, lti;
    bit gev, ltv;
    n = (cnt > 8) ? 8 : cnt;
    v = 0; f = 0; ix = 0; gev = 0; ltv = 0; gef = 0; ltf = 0; gei = 0; lti = 0;
    for (int i = 0; i < n; i++) begin
      if (md) begin
        if (!v && tbl_khz[i] == req) begin v = 1; ix = i; f = req; end
      end else if (tbl_khz[i] >= req) begin
        if (!gev || tbl_khz[i] < gef) begin gev = 1; gef = tbl_khz[i]; gei = i; end
      end else begin
        if (!ltv || tbl_khz[i] > ltf) begin ltv = 1; ltf = tbl_khz[i]; lti = i; end
      end
    end
    if (!md) begin
      if (gev) begin v = 1; f = gef; ix = gei; end
      else if (ltv) begin v = 1; f = ltf; ix = lti; end
    end
  endtask

  // run one search; jam holds start high with other inputs during the scan
  task automatic run(input bit md, input int req, input int cnt, input bit jam, output int lat);
    @(negedge clk);
    start_i = 1'b1; mode_i = md; req_khz_i = 25'(req); count_i = 4'(cnt);
    @(negedge clk);
    start_i = jam; mode_i = ~md; req_khz_i = 25'(req + 20); count_i = 4'd3;
    lat = 0;
    while (!done_o && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    start_i = 1'b0;
  endtask

  task automatic search_check(input bit md, input int req, input int cnt, input bit jam);
    bit v; int f, ix, lat, n, elat;
    string tag;
    model(md, req, cnt, v, f, ix);
    run(md, req, cnt, jam, lat);
    n = (cnt > 8) ? 8 : cnt;
    elat = (n == 0) ? 1 : n;
    chk(lat == elat, jam ? "R2 latency under busy start" : "R4 R3 latency", lat, elat);
    if (n == 0)      tag = "R9 empty";
    else if (md)     tag = v ? "R7 exact" : "R8 exact miss";
    else             tag = (f >= req) ? "R5 round up" : "R6 round fallback";
    if (jam) tag = {tag, " R2"};
    chk(valid_o == v, tag, int'(valid_o), int'(v));
    chk(int'(freq_khz_o) == f, {tag, " freq R1"}, int'(freq_khz_o), f);
    if (v) begin
      if (md) chk(int'(idx_o) == ix, {tag, " idx"}, int'(idx_o), ix);
      else    chk(int'(idx_o) < n && tbl_khz[idx_o] == f, {tag, " idx R3"}, int'(idx_o), ix);
      chk(int'(mv_o) == tbl_mv[idx_o], {tag, " mv R1"}, int'(mv_o), tbl_mv[idx_o]);
    end else begin
      chk(idx_o == 3'd0 && mv_o == 12'd0, {tag, " zero R8"}, int'(idx_o), 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int reqs [26];
    rst_n = 1'b0; wr_en_i = 0; wr_idx_i = 0; wr_data_i = 0;
    start_i = 0; mode_i = 0; count_i = 0; req_khz_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !valid_o && freq_khz_o == 0, "reset state R4", int'(busy_o), 0);

    for (int pat = 1; pat <= 3; pat++) begin
      load(pat);
      reqs[0] = 0; reqs[1] = 25'h1FFFFFF;
      for (int j = 0; j < 8; j++) begin
        reqs[2 + 3*j] = tbl_khz[j] - 1;
        reqs[3 + 3*j] = tbl_khz[j];
        reqs[4 + 3*j] = tbl_khz[j] + 1;
      end
      for (int cnt = 0; cnt <= 9; cnt++)
        for (int md = 0; md < 2; md++)
          for (int r = 0; r < 26; r++)
            search_check(md[0], reqs[r], cnt, 1'b0);
    end

    // start pulses held during the scan, including the finishing edge (R2)
    for (int cnt = 0; cnt <= 8; cnt++) begin
      search_check(1'b0, tbl_khz[3] + 1, cnt, 1'b1);
      search_check(1'b1, tbl_khz[cnt % 8], cnt, 1'b1);
    end

    // result outputs hold after done (R10)
    begin
      bit v0; logic [24:0] f0; logic [2:0] i0;
      search_check(1'b0, tbl_khz[5], 6, 1'b0);
      v0 = valid_o; f0 = freq_khz_o; i0 = idx_o;
      repeat (4) @(negedge clk);
      chk(valid_o == v0 && freq_khz_o == f0 && idx_o == i0 && !done_o,
          "R10 result hold", int'(freq_khz_o), int'(f0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule